// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the register-access front end of a three-channel event timer. A bus master issues one-cycle requests that carry a 10-bit byte address inside a 1 KiB window, an access size of 1, 2, 4 or 8 bytes, a write flag and 64 bits of data. The block checks that each request is aligned to its size. It turns each legal sub-word access into an operation on a full 64-bit register. Read results come back one cycle after the request.

The block holds the capability word, the two-bit global control register and the free-running 64-bit main counter. The main counter advances once every sixteen clocks while the global enable is set. Per-channel configuration, comparator and delivery-route registers, and the interrupt status bits, live in the channel blocks. For these registers the block reads the channel's current value, merges in the written bytes and applies the write mask. It then hands the full 64-bit result over with a one-hot write strobe in the same cycle. When the counter is loaded while it runs, each channel whose interrupt-enable bit is set receives a restart pulse.

The counter is controlled by a two-state machine. `CNT_HALT` holds the count and keeps the prescaler cleared. `CNT_RUN` steps the prescaler and advances the count on every sixteenth edge. The transition *start* (HALT to RUN) is taken at the edge that writes global enable to 1. The transition *stop* (RUN to HALT) is taken at the edge that writes it to 0. A counter load takes priority in both states: it sets the count and clears the prescaler.

Top module: `evtmr_regif`

## Requirements
- R1: After reset, `rsp_valid` is 0, `rsp_rdata` is 0, `main_count` is 0 and both global control bits are 0.
- R2: An access is legal only if its size is 1, 2, 4 or 8 and the address is a multiple of the size. An illegal read returns all ones. An illegal write changes no register and raises no strobe.
- R3: A read smaller than 8 bytes returns the register shifted right by 8 × addr[2:0] and masked to the access size.
- R4: A write smaller than 8 bytes places the data (taken from the low bytes of `req_wdata`) into the byte lanes starting at addr[2:0]. All other bytes keep their old value.
- R5: The capability register at 0x000 is read-only and holds: revision 1 in [7:0], channel count minus one in [12:8], 1 in [13] (64-bit counter), 0 in [14], 1 in [15] (legacy routing), the vendor code in [31:16] and the tick period in femtoseconds in [63:32].
- R6: In the global control register at 0x010, only bit 0 (enable) and bit 1 (legacy routing) are writable. All other bits read as zero.
- R7: Channel n has its configuration at 0x100+0x20·n, its comparator at 0x108+0x20·n and its route at 0x110+0x20·n. The interrupt status is at 0x020, with bit n for channel n. A write to any of these raises exactly one strobe for that register and places the merged value on `ch_wdata`. For configuration writes, only the bits in 0x3F4E come from the write; the other bits come from the channel's current value. Reads return the channel's value.
- R8: While enabled, the main counter rises by one every 16 clocks. The first increment happens at the 16th edge after the edge that sets enable.
- R9: While disabled, the main counter holds its value.
- R10: A write to 0x0F0 loads the main counter. If enable is set at the time, `ch_restart[n]` pulses for each channel whose configuration bit 2 is 1. If enable is clear, no restart pulses.
- R11: Reads of undefined offsets, including channel slots beyond the channel count, return 0. Writes to them change nothing and raise no strobe.
- R12: `rsp_valid` is high in the cycle after a read request and low after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset in the register window |
| req_len | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, low-byte aligned |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| gcfg_enable | output | 1 | Global enable |
| gcfg_legacy | output | 1 | Legacy routing enable |
| main_count | output | 64 | Main counter value |
| ch_cfg_q | input | NCH·64 | Channel configuration values |
| ch_cmp_q | input | NCH·64 | Channel comparator values |
| ch_route_q | input | NCH·64 | Channel route values |
| ch_sts_q | input | NCH | Channel interrupt status bits |
| ch_cfg_we | output | NCH | Configuration write strobes |
| ch_cmp_we | output | NCH | Comparator write strobes |
| ch_route_we | output | NCH | Route write strobes |
| sts_we | output | 1 | Status write strobe |
| ch_wdata | output | 64 | Merged write value for the strobed register |
| ch_restart | output | NCH | Channel restart pulses |

## Verification
The bench drives the prescaler boundary by stopping the counter 15, 16 and 40 edges after start, and expects 0, 1 and 2 increments. A design with an off-by-one prescaler or a late state update fails these checks. Sub-word counter writes and reads at lanes 1, 4 and 6 expose a wrong shift or a write that clears the neighbouring bytes. The bench also checks misaligned and odd-size accesses, writes to a channel slot past the last channel, and a configuration write of all ones whose unmasked bits must come from the channel's old value. A design that decodes loosely or masks wrongly would raise a strobe, corrupt the counter, or leak bits outside 0x3F4E. The bench checks restart pulses both with the counter running and with it halted, so a design that restarts unconditionally is caught.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

    localparam int REG_W = 64;

    // Register index in 8-byte units (addr[9:3]); channel slots decoded apart
    localparam logic [6:0] QW_CAP  = 7'h00;
    localparam logic [6:0] QW_GCFG = 7'h02;
    localparam logic [6:0] QW_STS  = 7'h04;
    localparam logic [6:0] QW_CNT  = 7'h1E;

    localparam logic [REG_W-1:0] TCFG_WMASK = 64'h0000_0000_0000_3F4E;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAP,
        SEL_GCFG,
        SEL_STS,
        SEL_CNT,
        SEL_TCFG,
        SEL_TCMP,
        SEL_TROUTE
    } reg_sel_e;

    typedef enum logic {
        CNT_HALT,
        CNT_RUN
    } cnt_state_e;

endpackage

// File: rtl/evtmr_acc_chk.sv
module evtmr_acc_chk
    import evtmr_pkg::*;
(
    input  logic [2:0]       boff,
    input  logic [3:0]       len,
    output logic             ok,
    output logic [REG_W-1:0] len_mask,
    output logic [5:0]       shamt
);

    always_comb begin
        ok       = 1'b0;
        len_mask = '0;
        unique case (len)
            4'd1: begin
                ok       = 1'b1;
                len_mask = 64'h0000_0000_0000_00FF;
            end
            4'd2: begin
                ok       = (boff[0] == 1'b0);
                len_mask = 64'h0000_0000_0000_FFFF;
            end
            4'd4: begin
                ok       = (boff[1:0] == 2'b00);
                len_mask = 64'h0000_0000_FFFF_FFFF;
            end
            4'd8: begin
                ok       = (boff == 3'b000);
                len_mask = '1;
            end
            default: begin
                ok       = 1'b0;
                len_mask = '0;
            end
        endcase
        shamt = {boff, 3'b000};
    end

endmodule

// File: rtl/evtmr_decode.sv
module evtmr_decode
    import evtmr_pkg::*;
#(
    parameter int NCH  = 3,
    parameter int CH_W = 2
) (
    input  logic [6:0]      qw,
    output reg_sel_e        sel,
    output logic [CH_W-1:0] ch
);

    logic [2:0] slot;
    logic [1:0] sub;

    assign slot = qw[4:2];
    assign sub  = qw[1:0];

    always_comb begin
        sel = SEL_NONE;
        ch  = '0;
        if (qw == QW_CAP) begin
            sel = SEL_CAP;
        end else if (qw == QW_GCFG) begin
            sel = SEL_GCFG;
        end else if (qw == QW_STS) begin
            sel = SEL_STS;
        end else if (qw == QW_CNT) begin
            sel = SEL_CNT;
        end else if (qw[6:5] == 2'b01 && int'(slot) < NCH) begin
            ch = CH_W'(slot);
            unique case (sub)
                2'd0:    sel = SEL_TCFG;
                2'd1:    sel = SEL_TCMP;
                2'd2:    sel = SEL_TROUTE;
                default: sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/evtmr_main_cnt.sv
module evtmr_main_cnt
    import evtmr_pkg::*;
#(
    parameter int PRE_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_nxt,
    input  logic             load,
    input  logic [REG_W-1:0] load_val,
    output logic [REG_W-1:0] count
);

    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    cnt_state_e       state;
    logic [PRE_W-1:0] pre;

    // State register: start (HALT->RUN) / stop (RUN->HALT) follow the enable write
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CNT_HALT;
        else        state <= en_nxt ? CNT_RUN : CNT_HALT;
    end

    // Outputs: prescaler and count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre   <= '0;
            count <= '0;
        end else if (load) begin
            pre   <= '0;
            count <= load_val;
        end else begin
            unique case (state)
                CNT_HALT: pre <= '0;
                CNT_RUN: begin
                    if (pre == PRE_LAST) begin
                        pre   <= '0;
                        count <= count + 1'b1;
                    end else begin
                        pre <= pre + 1'b1;
                    end
                end
                default: pre <= '0;
            endcase
        end
    end

endmodule

// File: rtl/evtmr_regif.sv
module evtmr_regif
    import evtmr_pkg::*;
#(
    parameter int          NCH     = 3,
    parameter logic [15:0] VENDOR  = 16'h5A17,
    parameter logic [31:0] TICK_FS = 32'd64_000_000,
    parameter int          PRE_DIV = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [9:0]           req_addr,
    input  logic [3:0]           req_len,
    input  logic [63:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [63:0]          rsp_rdata,
    output logic                 gcfg_enable,
    output logic                 gcfg_legacy,
    output logic [63:0]          main_count,
    input  logic [NCH*64-1:0]    ch_cfg_q,
    input  logic [NCH*64-1:0]    ch_cmp_q,
    input  logic [NCH*64-1:0]    ch_route_q,
    input  logic [NCH-1:0]       ch_sts_q,
    output logic [NCH-1:0]       ch_cfg_we,
    output logic [NCH-1:0]       ch_cmp_we,
    output logic [NCH-1:0]       ch_route_we,
    output logic                 sts_we,
    output logic [63:0]          ch_wdata,
    output logic [NCH-1:0]       ch_restart
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [REG_W-1:0] CAP_VAL =
        {TICK_FS, VENDOR, 1'b1, 1'b0, 1'b1, 5'(NCH - 1), 8'd1};

    logic             acc_ok;
    logic [REG_W-1:0] len_mask;
    logic [5:0]       shamt;
    reg_sel_e         sel;
    logic [CH_W-1:0]  ch;
    logic [1:0]       gcfg_q;
    logic [1:0]       gcfg_nxt;
    logic [REG_W-1:0] reg_view;
    logic [REG_W-1:0] lane;
    logic [REG_W-1:0] merged;
    logic             wr_hit;
    logic             rd_req;
    logic             cnt_load;

    logic [REG_W-1:0] cfg_arr   [NCH];
    logic [REG_W-1:0] cmp_arr   [NCH];
    logic [REG_W-1:0] route_arr [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign cfg_arr[g]   = ch_cfg_q[g*64 +: 64];
        assign cmp_arr[g]   = ch_cmp_q[g*64 +: 64];
        assign route_arr[g] = ch_route_q[g*64 +: 64];
    end

    evtmr_acc_chk u_acc (
        .boff     (req_addr[2:0]),
        .len      (req_len),
        .ok       (acc_ok),
        .len_mask (len_mask),
        .shamt    (shamt)
    );

    evtmr_decode #(.NCH(NCH), .CH_W(CH_W)) u_dec (
        .qw  (req_addr[9:3]),
        .sel (sel),
        .ch  (ch)
    );

    // Full 64-bit view of the addressed register
    always_comb begin
        unique case (sel)
            SEL_CAP:    reg_view = CAP_VAL;
            SEL_GCFG:   reg_view = {62'd0, gcfg_q};
            SEL_STS:    reg_view = REG_W'(ch_sts_q);
            SEL_CNT:    reg_view = main_count;
            SEL_TCFG:   reg_view = cfg_arr[ch];
            SEL_TCMP:   reg_view = cmp_arr[ch];
            SEL_TROUTE: reg_view = route_arr[ch];
            default:    reg_view = '0;
        endcase
    end

    assign rd_req = req_valid && !req_write;
    assign wr_hit = req_valid && req_write && acc_ok;
    assign lane   = len_mask << shamt;
    assign merged = ((req_wdata << shamt) & lane) | (reg_view & ~lane);

    assign cnt_load = wr_hit && (sel == SEL_CNT);
    assign gcfg_nxt = (wr_hit && sel == SEL_GCFG) ? merged[1:0] : gcfg_q;
    assign sts_we   = wr_hit && (sel == SEL_STS);
    assign ch_wdata = (sel == SEL_TCFG) ? ((merged & TCFG_WMASK) | (reg_view & ~TCFG_WMASK))
                                        : merged;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ch_cfg_we[i]   = wr_hit && (sel == SEL_TCFG)   && (ch == CH_W'(i));
            ch_cmp_we[i]   = wr_hit && (sel == SEL_TCMP)   && (ch == CH_W'(i));
            ch_route_we[i] = wr_hit && (sel == SEL_TROUTE) && (ch == CH_W'(i));
            ch_restart[i]  = cnt_load && gcfg_q[0] && cfg_arr[i][2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcfg_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            gcfg_q    <= gcfg_nxt;
            rsp_valid <= rd_req;
            if (rd_req) begin
                rsp_rdata <= acc_ok ? ((reg_view >> shamt) & len_mask) : '1;
            end
        end
    end

    assign gcfg_enable = gcfg_q[0];
    assign gcfg_legacy = gcfg_q[1];

    evtmr_main_cnt #(.PRE_DIV(PRE_DIV)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_nxt   (gcfg_nxt[0]),
        .load     (cnt_load),
        .load_val (merged),
        .count    (main_count)
    );

endmodule

// File: rtl/evtmr_regif_chk.sv
module evtmr_regif_chk #(
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_write,
    input logic           acc_ok,
    input logic           cnt_load,
    input logic           rsp_valid,
    input logic [63:0]    rsp_rdata,
    input logic           gcfg_enable,
    input logic [63:0]    main_count,
    input logic [NCH-1:0] ch_cfg_we,
    input logic [NCH-1:0] ch_cmp_we,
    input logic [NCH-1:0] ch_route_we,
    input logic           sts_we,
    input logic [NCH-1:0] ch_restart
);

    AST_BAD_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !acc_ok) |=> (rsp_rdata == '1)); // R2

    AST_BAD_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !acc_ok) |->
        (ch_cfg_we == '0 && ch_cmp_we == '0 && ch_route_we == '0 && !sts_we && !cnt_load)); // R2

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ch_cfg_we, ch_cmp_we, ch_route_we, sts_we, cnt_load})); // R7

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (gcfg_enable && !cnt_load) |=>
        (main_count == $past(main_count) || main_count == $past(main_count) + 64'd1)); // R8

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!gcfg_enable && !cnt_load) |=> $stable(main_count)); // R9

    AST_RESTART_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_restart != '0) |-> (cnt_load && gcfg_enable)); // R10

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R12

endmodule

bind evtmr_regif evtmr_regif_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .acc_ok      (acc_ok),
    .cnt_load    (cnt_load),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .gcfg_enable (gcfg_enable),
    .main_count  (main_count),
    .ch_cfg_we   (ch_cfg_we),
    .ch_cmp_we   (ch_cmp_we),
    .ch_route_we (ch_route_we),
    .sts_we      (sts_we),
    .ch_restart  (ch_restart)
);

// File: tb/evtmr_regif_bench.sv
module evtmr_regif_bench;

    localparam int          NCH     = 3;
    localparam logic [15:0] VENDOR  = 16'h5A17;
    localparam logic [31:0] TICK_FS = 32'd64_000_000;
    localparam logic [63:0] ONES    = 64'hFFFF_FFFF_FFFF_FFFF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [9:0]        req_addr = '0;
    logic [3:0]        req_len = 4'd8;
    logic [63:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [63:0]       rsp_rdata;
    logic              gcfg_enable;
    logic              gcfg_legacy;
    logic [63:0]       main_count;
    logic [NCH*64-1:0] ch_cfg_q;
    logic [NCH*64-1:0] ch_cmp_q;
    logic [NCH*64-1:0] ch_route_q;
    logic [NCH-1:0]    ch_sts_q = 3'b101;
    logic [NCH-1:0]    ch_cfg_we;
    logic [NCH-1:0]    ch_cmp_we;
    logic [NCH-1:0]    ch_route_we;
    logic              sts_we;
    logic [63:0]       ch_wdata;
    logic [NCH-1:0]    ch_restart;

    // Channel register models (stimulus side)
    logic [63:0] m_cfg   [NCH];
    logic [63:0] m_cmp   [NCH];
    logic [63:0] m_route [NCH];

    int nvec = 0;
    int nbad = 0;

    // Strobe snapshot taken during the last write
    logic [NCH-1:0] s_cfg_we, s_cmp_we, s_route_we, s_restart;
    logic           s_sts_we;
    logic [63:0]    s_wdata;

    always #2 clk = ~clk;

    for (genvar g = 0; g < NCH; g++) begin : g_pack
        assign ch_cfg_q[g*64 +: 64]   = m_cfg[g];
        assign ch_cmp_q[g*64 +: 64]   = m_cmp[g];
        assign ch_route_q[g*64 +: 64] = m_route[g];
    end

    initial begin
        m_cfg[0] = 64'h34; m_cfg[1] = 64'h30; m_cfg[2] = 64'h74;
        for (int i = 0; i < NCH; i++) begin
            m_cmp[i]   = ONES;
            m_route[i] = '0;
        end
    end

    always @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (ch_cfg_we[i])   m_cfg[i]   <= ch_wdata;
            if (ch_cmp_we[i])   m_cmp[i]   <= ch_wdata;
            if (ch_route_we[i]) m_route[i] <= ch_wdata;
        end
    end

    evtmr_regif #(.NCH(NCH), .VENDOR(VENDOR), .TICK_FS(TICK_FS)) u_evtmr_regif (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .gcfg_enable(gcfg_enable), .gcfg_legacy(gcfg_legacy), .main_count(main_count),
        .ch_cfg_q(ch_cfg_q), .ch_cmp_q(ch_cmp_q), .ch_route_q(ch_route_q), .ch_sts_q(ch_sts_q),
        .ch_cfg_we(ch_cfg_we), .ch_cmp_we(ch_cmp_we), .ch_route_we(ch_route_we),
        .sts_we(sts_we), .ch_wdata(ch_wdata), .ch_restart(ch_restart)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [9:0] a, input logic [3:0] l, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_len = l; req_wdata = d;
        #1;
        s_cfg_we = ch_cfg_we; s_cmp_we = ch_cmp_we; s_route_we = ch_route_we;
        s_sts_we = sts_we; s_wdata = ch_wdata; s_restart = ch_restart;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R12 no rsp after write", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic do_rd(input logic [9:0] a, input logic [3:0] l, output logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_len = l;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12 rsp_valid", {63'd0, rsp_valid}, 64'd1);
        d = rsp_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic no_strobe();
        return (s_cfg_we == '0) && (s_cmp_we == '0) && (s_route_we == '0) && !s_sts_we;
    endfunction

    task automatic t_reset();
        chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk("R1 rsp_rdata", rsp_rdata, 64'd0);
        chk("R1 main_count", main_count, 64'd0);
        chk("R1 gcfg", {62'd0, gcfg_legacy, gcfg_enable}, 64'd0);
    endtask

    task automatic t_caps();
        logic [63:0] v;
        do_rd(10'h000, 4'd8, v);
        chk("R5 capability", v, {TICK_FS, VENDOR, 1'b1, 1'b0, 1'b1, 5'd2, 8'd1});
        do_rd(10'h002, 4'd2, v);
        chk("R3 cap vendor half", v, {48'd0, VENDOR});
        do_wr(10'h000, 4'd8, 64'd0);
        do_rd(10'h000, 4'd4, v);
        chk("R5 cap read-only", v, {32'd0, VENDOR, 16'hA201});
    endtask

    task automatic t_gcfg();
        logic [63:0] v;
        do_wr(10'h010, 4'd8, 64'hFFFF_FFFF_FFFF_FFFE);
        do_rd(10'h010, 4'd8, v);
        chk("R6 gcfg writable bits", v, 64'd2);
        chk("R6 legacy port", {63'd0, gcfg_legacy}, 64'd1);
        do_wr(10'h010, 4'd1, 64'h00);
        do_rd(10'h010, 4'd8, v);
        chk("R6 gcfg cleared", v, 64'd0);
    endtask

    task automatic t_undef();
        logic [63:0] v;
        do_rd(10'h008, 4'd8, v);
        chk("R11 undefined 0x008", v, 64'd0);
        do_rd(10'h3F8, 4'd8, v);
        chk("R11 undefined 0x3F8", v, 64'd0);
        do_wr(10'h018, 4'd8, ONES);
        chk("R11 undefined write no strobe", {63'd0, no_strobe()}, 64'd1);
        do_rd(10'h010, 4'd8, v);
        chk("R11 gcfg untouched", v, 64'd0);
        do_wr(10'h160, 4'd8, ONES);
        chk("R11 channel 3 slot no strobe", {63'd0, no_strobe()}, 64'd1);
        do_rd(10'h168, 4'd8, v);
        chk("R11 channel 3 read", v, 64'd0);
    endtask

    task automatic t_lanes();
        logic [63:0] v;
        do_wr(10'h0F0, 4'd8, 64'h1122_3344_5566_7788);
        do_rd(10'h0F0, 4'd8, v);
        chk("R10 counter load", v, 64'h1122_3344_5566_7788);
        do_wr(10'h0F6, 4'd2, 64'h0000_0000_0000_ABCD);
        do_rd(10'h0F0, 4'd8, v);
        chk("R4 lane merge at 6", v, 64'hABCD_3344_5566_7788);
        do_rd(10'h0F4, 4'd4, v);
        chk("R3 read 4 at 4", v, 64'h0000_0000_ABCD_3344);
        do_rd(10'h0F1, 4'd1, v);
        chk("R3 read 1 at 1", v, 64'h77);
    endtask

    task automatic t_illegal();
        logic [63:0] v;
        do_rd(10'h0F2, 4'd4, v);
        chk("R2 misaligned read", v, ONES);
        do_rd(10'h000, 4'd3, v);
        chk("R2 size 3 read", v, ONES);
        do_wr(10'h0F2, 4'd4, 64'h0);
        do_wr(10'h011, 4'd2, 64'h3);
        chk("R2 bad write no strobe", {63'd0, no_strobe()}, 64'd1);
        do_rd(10'h0F0, 4'd8, v);
        chk("R2 counter kept", v, 64'hABCD_3344_5566_7788);
        chk("R2 enable kept", {63'd0, gcfg_enable}, 64'd0);
    endtask

    task automatic t_rate();
        logic [63:0] v;
        do_wr(10'h0F0, 4'd8, 64'd1000);
        do_wr(10'h010, 4'd8, 64'd1);
        idle(13);
        do_wr(10'h010, 4'd8, 64'd0);          // stop 15 edges after start
        do_rd(10'h0F0, 4'd8, v);
        chk("R8 no step before 16", v, 64'd1000);
        do_wr(10'h010, 4'd8, 64'd1);
        idle(14);
        do_wr(10'h010, 4'd8, 64'd0);          // stop 16 edges after start
        do_rd(10'h0F0, 4'd8, v);
        chk("R8 step at 16", v, 64'd1001);
        do_wr(10'h010, 4'd8, 64'd1);
        idle(38);
        do_wr(10'h010, 4'd8, 64'd0);          // stop 40 edges after start
        do_rd(10'h0F0, 4'd8, v);
        chk("R8 two steps in 40", v, 64'd1003);
        idle(40);
        do_rd(10'h0F0, 4'd8, v);
        chk("R9 halted holds", v, 64'd1003);
    endtask

    task automatic t_restart();
        logic [63:0] v;
        do_wr(10'h010, 4'd8, 64'd1);
        do_wr(10'h0F0, 4'd8, 64'h100);
        chk("R10 restart while running", {61'd0, s_restart}, 64'b101);
        do_wr(10'h010, 4'd8, 64'd0);
        do_rd(10'h0F0, 4'd8, v);
        chk("R10 loaded while running", v, 64'h100);
        do_wr(10'h0F0, 4'd8, 64'h200);
        chk("R10 no restart when halted", {61'd0, s_restart}, 64'd0);
    endtask

    task automatic t_channel();
        logic [63:0] v;
        logic [63:0] old;
        old = m_cfg[1];
        do_wr(10'h120, 4'd8, ONES);
        chk("R7 cfg strobe ch1", {61'd0, s_cfg_we}, 64'b010);
        chk("R7 cfg masked value", s_wdata, (ONES & 64'h3F4E) | (old & ~64'h3F4E));
        do_rd(10'h120, 4'd8, v);
        chk("R7 cfg readback", v, 64'h3F7E);
        do_wr(10'h128, 4'd1, 64'h5A);
        chk("R7 cmp strobe ch1", {61'd0, s_cmp_we}, 64'b010);
        chk("R4 cmp byte merge", s_wdata, 64'hFFFF_FFFF_FFFF_FF5A);
        do_wr(10'h154, 4'd4, 64'hDEAD_BEEF);
        chk("R7 route strobe ch2", {61'd0, s_route_we}, 64'b100);
        chk("R4 route upper half", s_wdata, 64'hDEAD_BEEF_0000_0000);
        do_rd(10'h020, 4'd1, v);
        chk("R7 status read", v, 64'd5);
        do_wr(10'h020, 4'd8, 64'd1);
        chk("R7 status strobe", {63'd0, s_sts_we}, 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_caps();
        t_gcfg();
        t_undef();
        t_lanes();
        t_illegal();
        t_rate();
        t_restart();
        t_channel();
        idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        nvec++;
        nbad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule